// File: doc/BRIEF.md
# Self-Timed Dual-Rail Ripple Adder

This block adds two unsigned WIDTH-bit operands and a carry-in. Every sum bit and every internal carry is held as a pair of wires, a true rail and a false rail, instead of one wire. Pair `{t,f}` = `10` means logic 1, `01` means logic 0, and `00` means that no value is present yet. The code `11` is illegal. Because an unresolved pair can be told apart from a resolved one, the adder signals when it has finished. It does not rely on a fixed worst-case carry delay.

The adder starts with every pair at null. Raising `go` lets the carry-in enter bit 0 as a valid pair. Each bit position has a register stage, so a carry that has to ripple through a run of propagate positions (where a differs from b) moves one bit per clock. A position where a equals b settles its carry-out at once, without waiting for its carry-in. `done` rises in the cycle when the last sum pair and the final carry pair have both resolved. When `go` falls, every pair goes back to null. The binary result is taken from the true rails. It is meaningful only while `done` is high.

Top module: `dr_ripple_adder`

## Requirements
- R1: Each output pair uses `{t,f}` with 10 = logic 1, 01 = logic 0, 00 = null. The code 11 never appears on `sum_t/sum_f` or `cout_t/cout_f`.
- R2: On the first clock edge where `go` is sampled low, every sum and carry pair returns to 00 and `done` goes low. This holds even when a computation is still in flight.
- R3: While `done` is high, `{cout, sum}` equals `a + b + cin`, and `sum`/`cout` equal the true rails.
- R4: Counting edges from the first edge with `go` high (edge 1), the carry into bit 0 is valid at edge 0. Sum pair i is valid one edge after its carry-in is valid. The carry-out of bit i is valid at edge 1 when a[i] equals b[i]. Otherwise it is valid one edge after its carry-in. Until those edges the pair reads 00.
- R5: `done` is high exactly when every sum pair and the final carry pair hold 01 or 10. It is never high earlier.
- R6: With `go` held high and the operands held steady, `done` and the result stay unchanged once `done` has risen.
- R7: `err` is a sticky flag. It is set if any registered sum or carry pair is ever seen at 11, and only reset clears it. Correct operation leaves it at 0.
- R8: While `rst_n` is low at a clock edge, all pairs clear to 00, and `done` and `err` read 0, whatever `go` and the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start; low forces every pair to null |
| a | input | WIDTH | Operand A, held steady while go is high |
| b | input | WIDTH | Operand B, held steady while go is high |
| cin | input | 1 | Carry into bit 0 |
| sum_t | output | WIDTH | True rails of the sum pairs |
| sum_f | output | WIDTH | False rails of the sum pairs |
| cout_t | output | 1 | True rail of the final carry |
| cout_f | output | 1 | False rail of the final carry |
| sum | output | WIDTH | Decoded sum (true rails) |
| cout | output | 1 | Decoded carry-out |
| done | output | 1 | Completion: all sum pairs and final carry resolved |
| err | output | 1 | Sticky forbidden-code flag |

## Verification
The main risk is that completion detection and the final carry settle on the same edge. This happens when the carry runs the full length of the adder. In that case `done` must rise on exactly that edge: not one edge early on a partly null vector, and not one edge late. Operands made of all-propagate bits with the carry-in set, together with random operands that give every chain length, provoke this. After every edge the bench compares the full rail state against a resolution mask it computes from the carry-chain rule. A second overlap is the fall of `go` arriving while the chain is still rippling. The bench judges it by requiring a complete null on the very next edge.

// File: rtl/dr_pkg.sv
// Package dr_pkg
// Shared encoding for the dual-rail adder: the pair type and helpers that
// classify a pair as null, valid or forbidden. Assumes {t,f} ordering.
package dr_pkg;

    typedef struct packed {
        logic t;   // true rail: asserted for logic 1
        logic f;   // false rail: asserted for logic 0
    } dr_pair_t;

    localparam dr_pair_t PAIR_NULL = '{t: 1'b0, f: 1'b0};

    // Encode a single-rail bit as a resolved pair.
    function automatic dr_pair_t pair_of(input logic v);
        return '{t: v, f: ~v};
    endfunction

    // A pair holds data when exactly one rail is up.
    function automatic logic pair_valid(input dr_pair_t p);
        return p.t ^ p.f;
    endfunction

    // Both rails up is an illegal code.
    function automatic logic pair_bad(input dr_pair_t p);
        return p.t & p.f;
    endfunction

endpackage

// File: rtl/dr_bit_cell.sv
// Module dr_bit_cell
// Combinational full-adder slice in split-rail form. Operands are single
// rail; carry-in, sum and carry-out are dual-rail pairs. Assumes the
// carry-in pair is never 11. A null carry-in keeps the sum null, and it
// keeps the carry-out null unless a equals b (generate or kill).
module dr_bit_cell
    import dr_pkg::*;
(
    input  logic     a,
    input  logic     b,
    input  dr_pair_t cin,
    output dr_pair_t sum,
    output dr_pair_t cout
);

    logic prop;   // a and b differ: carry passes through

    // Purpose: classify the position as propagate or not.
    always_comb begin
        prop = a ^ b;
    end

    // Purpose: sum rails, each steered by one carry rail.
    always_comb begin
        sum.t = (prop & cin.f) | (~prop & cin.t);
        sum.f = (prop & cin.t) | (~prop & cin.f);
    end

    // Purpose: carry rails; generate/kill resolve without the carry-in.
    always_comb begin
        cout.t = (a & b)   | (prop & cin.t);
        cout.f = (~a & ~b) | (prop & cin.f);
    end

endmodule

// File: rtl/dr_reduce_tree.sv
// Module dr_reduce_tree
// Balanced binary reduction over LANES inputs, built as a heap-ordered
// node array. USE_AND selects an AND tree (completion) or an OR tree
// (fault gathering); unused leaves are padded with the identity value.
module dr_reduce_tree #(
    parameter int LANES   = 9,
    parameter bit USE_AND = 1'b1
) (
    input  logic [LANES-1:0] lane,
    output logic             result
);

    localparam int LEAVES = (LANES < 2) ? 2 : (1 << $clog2(LANES));
    localparam int NODES  = 2 * LEAVES - 1;
    localparam logic PAD  = USE_AND;

    logic [NODES-1:0] node;

    // Purpose: fill leaves, then fold internal nodes from the bottom up.
    always_comb begin
        node = '0;
        for (int i = 0; i < LEAVES; i++) begin
            node[LEAVES - 1 + i] = (i < LANES) ? lane[i] : PAD;
        end
        for (int k = LEAVES - 2; k >= 0; k--) begin
            if (USE_AND) begin
                node[k] = node[2*k + 1] & node[2*k + 2];
            end else begin
                node[k] = node[2*k + 1] | node[2*k + 2];
            end
        end
    end

    // Purpose: present the root.
    always_comb begin
        result = node[0];
    end

endmodule

// File: rtl/dr_ripple_adder.sv
// Module dr_ripple_adder
// WIDTH-bit dual-rail ripple adder with completion. Each bit slice's sum
// and carry-out pairs are registered, so a propagate run advances one bit
// per clock. While go is low every pair is held at null. done is the
// AND of the sum valids and the final carry valid. err is a sticky OR of
// forbidden codes in the registered pairs.
// Assumes a, b and cin are stable while go is high.
module dr_ripple_adder
    import dr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum_t,
    output logic [WIDTH-1:0] sum_f,
    output logic             cout_t,
    output logic             cout_f,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             done,
    output logic             err
);

    localparam int DONE_LANES = WIDTH + 1;
    localparam int BAD_LANES  = 2 * WIDTH;

    dr_pair_t                  carry_in0;
    dr_pair_t [WIDTH-1:0]      cell_cin;
    dr_pair_t [WIDTH-1:0]      cell_sum;
    dr_pair_t [WIDTH-1:0]      cell_cout;
    dr_pair_t [WIDTH-1:0]      sum_q;
    dr_pair_t [WIDTH-1:0]      carry_q;
    logic     [DONE_LANES-1:0] valid_vec;
    logic     [BAD_LANES-1:0]  bad_vec;
    logic                      all_valid;
    logic                      any_bad;
    logic                      err_q;

    // Purpose: admit the external carry only once go is high.
    always_comb begin
        carry_in0 = go ? pair_of(cin) : PAIR_NULL;
    end

    // Slices: each takes its carry from the register of the slice below.
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        if (i == 0) begin : g_lsb
            assign cell_cin[i] = carry_in0;
        end else begin : g_upper
            assign cell_cin[i] = carry_q[i-1];
        end

        dr_bit_cell u_cell (
            .a    (a[i]),
            .b    (b[i]),
            .cin  (cell_cin[i]),
            .sum  (cell_sum[i]),
            .cout (cell_cout[i])
        );
    end

    // Purpose: capture slice outputs; reset or idle forces every pair to null.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q   <= '0;
            carry_q <= '0;
        end else if (!go) begin
            sum_q   <= '0;
            carry_q <= '0;
        end else begin
            sum_q   <= cell_sum;
            carry_q <= cell_cout;
        end
    end

    // Purpose: gather per-pair valid and forbidden flags for the trees.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            valid_vec[i]         = pair_valid(sum_q[i]);
            bad_vec[i]           = pair_bad(sum_q[i]);
            bad_vec[WIDTH + i]   = pair_bad(carry_q[i]);
        end
        valid_vec[WIDTH] = pair_valid(carry_q[WIDTH-1]);
    end

    dr_reduce_tree #(
        .LANES   (DONE_LANES),
        .USE_AND (1'b1)
    ) u_done_tree (
        .lane   (valid_vec),
        .result (all_valid)
    );

    dr_reduce_tree #(
        .LANES   (BAD_LANES),
        .USE_AND (1'b0)
    ) u_bad_tree (
        .lane   (bad_vec),
        .result (any_bad)
    );

    // Purpose: latch any forbidden code until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_q | any_bad;
        end
    end

    // Purpose: split the registered pairs onto the output rails.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            sum_t[i] = sum_q[i].t;
            sum_f[i] = sum_q[i].f;
        end
        cout_t = carry_q[WIDTH-1].t;
        cout_f = carry_q[WIDTH-1].f;
    end

    // Purpose: single-rail decode and status outputs.
    always_comb begin
        sum  = sum_t;
        cout = cout_t;
        done = all_valid;
        err  = err_q;
    end

endmodule

// File: rtl/dr_ripple_adder_chk.sv
// Module dr_ripple_adder_chk
// Protocol checker for dr_ripple_adder, attached by bind. Watches only
// the top-level ports. Assumes operands are held while go is high.
module dr_ripple_adder_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum_t,
    input logic [WIDTH-1:0] sum_f,
    input logic             cout_t,
    input logic             cout_f,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic             done,
    input logic             err
);

    localparam int RW = WIDTH + 1;

    p_no_forbidden_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((sum_t & sum_f) == '0) && !(cout_t && cout_f));

    p_idle_null_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (sum_t == '0) && (sum_f == '0) && !cout_t && !cout_f && !done);

    p_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ({cout, sum} == ({1'b0, a} + {1'b0, b} + RW'(cin))));

    p_done_complete_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((sum_t ^ sum_f) == {WIDTH{1'b1}}) && (cout_t ^ cout_f));

    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && go) |=> (done || !go || !$stable(a) || !$stable(b) || !$stable(cin)));

    p_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !err);

    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (sum_t == '0) && (sum_f == '0) && !done && !err);

endmodule

bind dr_ripple_adder dr_ripple_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .a      (a),
    .b      (b),
    .cin    (cin),
    .sum_t  (sum_t),
    .sum_f  (sum_f),
    .cout_t (cout_t),
    .cout_f (cout_f),
    .sum    (sum),
    .cout   (cout),
    .done   (done),
    .err    (err)
);

// File: tb/tb_dr_ripple_adder.sv
`timescale 1ns/1ps
module tb_dr_ripple_adder;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         go = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum_t, sum_f, sum;
    logic         cout_t, cout_f, cout, done, err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dr_ripple_adder #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .go(go), .a(a), .b(b), .cin(cin),
        .sum_t(sum_t), .sum_f(sum_f), .cout_t(cout_t), .cout_f(cout_f),
        .sum(sum), .cout(cout), .done(done), .err(err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Edge at which sum pair i resolves (sum_time) and the final carry resolves.
    task automatic timing(input logic [W-1:0] x, input logic [W-1:0] y,
                          output int st[W], output int ct_out, output int last);
        int ct = 0;
        last = 0;
        for (int i = 0; i < W; i++) begin
            st[i] = ct + 1;
            if (st[i] > last) last = st[i];
            ct = (x[i] ^ y[i]) ? ct + 1 : 1;
        end
        ct_out = ct;
        if (ct > last) last = ct;
    endtask

    function automatic logic [63:0] pack_state(input logic [W-1:0] t, input logic [W-1:0] f,
                                               input logic ct, input logic cf, input logic d);
        return {t, f, ct, cf, d};
    endfunction

    task automatic run_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        int st[W];
        int ctime, last;
        logic [W:0] full;
        logic [W-1:0] mask, et, ef;
        timing(x, y, st, ctime, last);
        full = {1'b0, x} + {1'b0, y} + (W+1)'(c);
        @(negedge clk);
        a = x; b = y; cin = c; go = 1'b1;
        for (int k = 1; k <= W + 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            for (int i = 0; i < W; i++) mask[i] = (k >= st[i]);
            et = full[W-1:0] & mask;
            ef = ~full[W-1:0] & mask;
            // R4 R5 R1: rail state per edge against the resolution mask
            check("R4/R5 rails+done", pack_state(sum_t, sum_f, cout_t, cout_f, done),
                  pack_state(et, ef, (k >= ctime) & full[W], (k >= ctime) & ~full[W], k >= last));
            if (k >= last) begin
                // R3 decoded result; R6 held steady once done
                check("R3 R6 result", {cout, sum}, full);
            end
        end
        @(negedge clk);
        go = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R2 return to null
        check("R2 null after go low", pack_state(sum_t, sum_f, cout_t, cout_f, done), 64'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        // R8 reset clears even with go high
        a = 8'hA5; b = 8'h5A; cin = 1'b1; go = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset pairs", pack_state(sum_t, sum_f, cout_t, cout_f, done), 64'd0);
        check("R8 reset err", {63'd0, err}, 64'd0);
        go = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        run_add(8'hFF, 8'h00, 1'b1);   // full ripple, last carry and done coincide
        run_add(8'hFF, 8'h00, 1'b0);
        run_add(8'h00, 8'h00, 1'b0);
        run_add(8'hFF, 8'hFF, 1'b1);   // all generate
        run_add(8'h0F, 8'hF0, 1'b1);
        run_add(8'h80, 8'h80, 1'b0);

        // R2 abort mid-ripple
        @(negedge clk);
        a = 8'hFF; b = 8'h00; cin = 1'b1; go = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R5 not done mid-ripple", {63'd0, done}, 64'd0);
        go = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R2 abort null", pack_state(sum_t, sum_f, cout_t, cout_f, done), 64'd0);

        // Random operands, fixed seed
        void'($urandom(32'd1234));
        for (int n = 0; n < 300; n++) begin
            logic [W-1:0] x, y;
            x = W'($urandom);
            y = (n % 3 == 0) ? ~x : W'($urandom);   // bias toward long chains
            run_add(x, y, 1'($urandom));
        end

        // R7 sticky error never set
        check("R7 err clear", {63'd0, err}, 64'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule